// File: doc/BRIEF.md
# Masked BCD Calendar Alarm Comparator

This block watches a running packed-BCD calendar (second, minute, hour, day of month, month, year) that a separate counter delivers on its input ports. It compares the calendar against six alarm bytes that software programs through a byte-wide register port. Software can drop any field from the comparison so that it acts as a wildcard. For example, enabling only second, minute and hour gives an alarm that fires once a day.

A control byte holds one enable bit per field and a global enable bit. A match is registered only on the cycle where the masked comparison turns from false to true. That cycle sets a sticky pending bit, which software clears by writing a one to it. The level interrupt output is the pending bit gated by the global enable. Software can silence the interrupt without losing the programmed alarm. Writing zero to the control byte stops all matching while the alarm fields are rewritten.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, every register (addresses 0 to 7) reads 0x00 and `alarmIrq` is low.
- R2: Addresses 0..5 hold the alarm bytes for second, minute, hour, day of month, month and year, and each reads back the last byte written to it. Address 6 is the control byte. Its bits 0..5 enable the fields in that same order, bit 7 is the global enable, and bit 6 is not stored and reads 0.
- R3: With the global enable set, the match condition is true when every enabled field byte equals its calendar byte exactly. The month is compared in its 0x01..0x12 BCD form.
- R4: A field whose enable bit is 0 is ignored: any calendar value in it leaves the match outcome unchanged.
- R5: Writing the control byte with bit 7 clear drives `alarmIrq` low after that write's clock edge. It leaves the alarm bytes, the field enables and the pending bit as they were.
- R6: The pending bit (address 7, bit 0) is set only at the clock edge where the match condition goes from false to true. A match that persists does not set it again after it is cleared.
- R7: With the global enable set and all six field enables clear, no calendar value sets the pending bit.
- R8: Writing address 7 with bit 0 set clears the pending bit, and writing it with bit 0 clear has no effect. If a new match rise and a clear happen at the same edge, the pending bit ends up set.
- R9: `alarmIrq` is high exactly when the pending bit is set and the global enable is set. It rises at the same clock edge that captures the matching calendar value.
- R10: While the control byte is 0x00, programming the alarm bytes to equal the current calendar does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calSec | input | 8 | Calendar second, BCD |
| calMin | input | 8 | Calendar minute, BCD |
| calHour | input | 8 | Calendar hour, BCD |
| calDay | input | 8 | Calendar day of month, BCD |
| calMon | input | 8 | Calendar month 0x01..0x12, BCD |
| calYear | input | 8 | Calendar year, BCD |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write byte |
| regRdata | output | 8 | Register read byte (combinational on regAddr) |
| alarmIrq | output | 1 | Level alarm interrupt |

## Verification
The bench builds the block with its package defaults: six 8-bit fields and an eight-entry register space. With these values every field, the control byte and the pending register can be reached through the 3-bit address. A vector table runs a second/minute/hour alarm against calendars that differ in one field at a time, while the day, month and year vary freely as wildcards. Directed tests then cover:
- a match that persists across a clear,
- a clear and a new match landing at the same edge,
- toggling the global enable around a pending bit,
- a zero control byte during reprogramming,
- a month-only alarm at 0x12.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int DATA_W     = 8;
  localparam int NUM_REGS   = 8;
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int CTRL_IDX   = NUM_FIELDS;
  localparam int PEND_IDX   = NUM_FIELDS + 1;
  localparam int GLOBAL_BIT = DATA_W - 1;
  localparam int CAL_W      = NUM_FIELDS * DATA_W;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldWr;
    logic                  ctlWr;
    logic                  pendClr;
  } alarmStrobe_t;
endpackage

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  alarmStrobe_t          strobe,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [CAL_W-1:0]      calFlat,
  input  logic                  pendQ,
  output logic [DATA_W-1:0]     rdData,
  output logic                  matchNow,
  output logic                  globalEn,
  output logic [NUM_FIELDS-1:0] fieldEn
);
  logic [DATA_W-1:0]     almField [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldHit;
  logic [DATA_W-1:0]     ctlByte;

  // One storage byte and one masked comparator per calendar field
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)                  almField[i] <= '0;
      else if (strobe.fieldWr[i]) almField[i] <= wrData;
    end
    assign fieldHit[i] = ~fieldEn[i] |
                         (calFlat[i*DATA_W +: DATA_W] == almField[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldEn  <= '0;
      globalEn <= 1'b0;
    end else if (strobe.ctlWr) begin
      fieldEn  <= wrData[NUM_FIELDS-1:0];
      globalEn <= wrData[GLOBAL_BIT];
    end
  end

  // Empty mask never matches
  assign matchNow = globalEn & (|fieldEn) & (&fieldHit);

  always_comb begin
    ctlByte                   = '0;
    ctlByte[NUM_FIELDS-1:0]   = fieldEn;
    ctlByte[GLOBAL_BIT]       = globalEn;
  end

  always_comb begin
    rdData = '0;
    if (int'(rdAddr) < NUM_FIELDS)       rdData = almField[rdAddr];
    else if (int'(rdAddr) == CTRL_IDX)   rdData = ctlByte;
    else if (int'(rdAddr) == PEND_IDX)   rdData[0] = pendQ;
  end
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              clrBit,
  input  logic              matchNow,
  input  logic              globalEn,
  output alarmStrobe_t      strobe,
  output logic              pendQ,
  output logic              matchPrevQ,
  output logic              alarmIrq
);
  logic matchRise;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign strobe.fieldWr[i] = regWe && (regAddr == ADDR_W'(i));
  end
  assign strobe.ctlWr   = regWe && (regAddr == ADDR_W'(CTRL_IDX));
  assign strobe.pendClr = regWe && (regAddr == ADDR_W'(PEND_IDX)) && clrBit;

  assign matchRise = matchNow & ~matchPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPrevQ <= 1'b0;
      pendQ      <= 1'b0;
    end else begin
      matchPrevQ <= matchNow;
      pendQ      <= matchRise | (pendQ & ~strobe.pendClr);
    end
  end

  assign alarmIrq = pendQ & globalEn;
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] calSec,
  input  logic [DATA_W-1:0] calMin,
  input  logic [DATA_W-1:0] calHour,
  input  logic [DATA_W-1:0] calDay,
  input  logic [DATA_W-1:0] calMon,
  input  logic [DATA_W-1:0] calYear,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              alarmIrq
);
  alarmStrobe_t          strobe;
  logic                  pendQ;
  logic                  matchPrevQ;
  logic                  matchNow;
  logic                  globalEn;
  logic [NUM_FIELDS-1:0] fieldEn;
  logic [CAL_W-1:0]      calFlat;

  assign calFlat = {calYear, calMon, calDay, calHour, calMin, calSec};

  alarm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .clrBit(regWdata[0]), .matchNow(matchNow), .globalEn(globalEn),
    .strobe(strobe), .pendQ(pendQ), .matchPrevQ(matchPrevQ),
    .alarmIrq(alarmIrq)
  );

  alarm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWdata),
    .rdAddr(regAddr), .calFlat(calFlat), .pendQ(pendQ),
    .rdData(regRdata), .matchNow(matchNow), .globalEn(globalEn),
    .fieldEn(fieldEn)
  );
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
  import alarm_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [ADDR_W-1:0]     regAddr,
  input logic [DATA_W-1:0]     regWdata,
  input logic                  alarmIrq,
  input logic                  pendQ,
  input logic                  matchNow,
  input logic                  matchPrevQ,
  input logic                  globalEn,
  input logic [NUM_FIELDS-1:0] fieldEn
);
  a_r5_disable_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(CTRL_IDX) && !regWdata[GLOBAL_BIT]) |=> !alarmIrq);

  a_r6_set_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> ($past(matchNow) && !$past(matchPrevQ)));

  a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (globalEn && fieldEn == '0) |-> !matchNow);

  a_r8_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(PEND_IDX) && regWdata[0] &&
     !(matchNow && !matchPrevQ)) |=> !pendQ);

  a_r10_zero_ctl: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(CTRL_IDX) && regWdata == '0) |=> !matchNow);
endmodule

bind bcd_alarm_match alarm_match_chk u_chk (.*);

// File: tb/test_bcd_alarm_match.sv
`timescale 1ns/1ps
module test_bcd_alarm_match;
  logic clk = 0, rstN = 0;
  logic [7:0] calSec, calMin, calHour, calDay, calMon, calYear;
  logic regWe = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] regWdata = 0;
  logic [7:0] regRdata;
  logic alarmIrq;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_alarm_match i_bcd_alarm_match (.*);

  // sec, min, hour, day, month, year, expected pending
  localparam logic [48:0] VEC [8] = '{
    {8'h30, 8'h15, 8'h08, 8'h01, 8'h01, 8'h00, 1'b1},
    {8'h31, 8'h15, 8'h08, 8'h01, 8'h01, 8'h00, 1'b0},
    {8'h30, 8'h16, 8'h08, 8'h02, 8'h03, 8'h10, 1'b0},
    {8'h30, 8'h15, 8'h09, 8'h01, 8'h01, 8'h00, 1'b0},
    {8'h30, 8'h15, 8'h08, 8'h31, 8'h12, 8'h99, 1'b1},
    {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b0},
    {8'h30, 8'h15, 8'h08, 8'h15, 8'h06, 8'h24, 1'b1},
    {8'h29, 8'h15, 8'h08, 8'h15, 8'h06, 8'h24, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #0.5; d = regRdata;
  endtask

  task automatic setCal(input logic [7:0] s, m, h, dd, mo, y);
    calSec = s; calMin = m; calHour = h; calDay = dd; calMon = mo; calYear = y;
  endtask

  task automatic noMatch();
    @(negedge clk); setCal(8'h59, 8'h59, 8'h23, 8'h28, 8'h11, 8'h77);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    setCal(8'h59, 8'h59, 8'h23, 8'h28, 8'h11, 8'h77);
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rdReg(3'(a), d); chk("R1 reset reg", d, 8'h00);
    end
    chk("R1 irq", {7'b0, alarmIrq}, 8'h00);

    // R2 readback, control bit 6 not stored
    wrReg(3'd6, 8'hFF); rdReg(3'd6, d); chk("R2 ctl", d, 8'hBF);
    wrReg(3'd6, 8'h00);
    wrReg(3'd4, 8'hA5); rdReg(3'd4, d); chk("R2 month byte", d, 8'hA5);

    // program sec/min/hour alarm, day/month/year wildcards (R4)
    wrReg(3'd0, 8'h30); wrReg(3'd1, 8'h15); wrReg(3'd2, 8'h08);
    wrReg(3'd3, 8'h44); wrReg(3'd4, 8'h07); wrReg(3'd5, 8'h55);
    wrReg(3'd6, 8'h87);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      setCal(VEC[v][48:41], VEC[v][40:33], VEC[v][32:25],
             VEC[v][24:17], VEC[v][16:9], VEC[v][8:1]);
      rdReg(3'd7, d);
      chk("R3 R4 table pending", d, {7'b0, VEC[v][0]});
      chk("R9 table irq", {7'b0, alarmIrq}, {7'b0, VEC[v][0]});
      wrReg(3'd7, 8'h01);
      noMatch();
    end

    // R6 persisting match after clear does not re-set
    @(negedge clk); setCal(8'h30, 8'h15, 8'h08, 8'h01, 8'h01, 8'h00);
    wrReg(3'd7, 8'h01);
    repeat (3) @(negedge clk);
    rdReg(3'd7, d); chk("R6 held match", d, 8'h00);

    // R8 writing zero does nothing
    noMatch();
    @(negedge clk); setCal(8'h30, 8'h15, 8'h08, 8'h01, 8'h01, 8'h00);
    wrReg(3'd7, 8'h00); rdReg(3'd7, d); chk("R8 write zero", d, 8'h01);

    // R5 global disable silences irq, keeps state
    wrReg(3'd6, 8'h07);
    chk("R5 irq low", {7'b0, alarmIrq}, 8'h00);
    rdReg(3'd7, d); chk("R5 pending kept", d, 8'h01);
    rdReg(3'd0, d); chk("R5 field kept", d, 8'h30);
    rdReg(3'd6, d); chk("R5 enables kept", d, 8'h07);
    wrReg(3'd6, 8'h87);
    chk("R9 irq back", {7'b0, alarmIrq}, 8'h01);
    wrReg(3'd7, 8'h01); rdReg(3'd7, d); chk("R8 clear", d, 8'h00);

    // R8 set wins over clear at the same edge
    noMatch();
    @(negedge clk);
    setCal(8'h30, 8'h15, 8'h08, 8'h01, 8'h01, 8'h00);
    regWe = 1; regAddr = 3'd7; regWdata = 8'h01;
    @(negedge clk); regWe = 0;
    rdReg(3'd7, d); chk("R8 set wins", d, 8'h01);
    wrReg(3'd7, 8'h01);

    // R7 empty mask never fires
    noMatch();
    wrReg(3'd6, 8'h80);
    @(negedge clk); setCal(8'h30, 8'h15, 8'h08, 8'h01, 8'h01, 8'h00);
    repeat (2) @(negedge clk);
    setCal(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (2) @(negedge clk);
    rdReg(3'd7, d); chk("R7 no fields", d, 8'h00);

    // R10 zero control while reprogramming
    wrReg(3'd6, 8'h00);
    @(negedge clk); setCal(8'h45, 8'h12, 8'h23, 8'h28, 8'h02, 8'h30);
    wrReg(3'd0, 8'h45); wrReg(3'd1, 8'h12); wrReg(3'd2, 8'h23);
    wrReg(3'd3, 8'h28); wrReg(3'd4, 8'h02); wrReg(3'd5, 8'h30);
    rdReg(3'd7, d); chk("R10 no pend", d, 8'h00);
    chk("R10 irq", {7'b0, alarmIrq}, 8'h00);

    // R3 month-only alarm at 0x12, R9 edge timing
    wrReg(3'd4, 8'h12);
    @(negedge clk); calMon = 8'h11;
    wrReg(3'd6, 8'h90);
    rdReg(3'd7, d); chk("R3 month 0x11 no match", d, 8'h00);
    @(negedge clk); calMon = 8'h12; #0.5;
    chk("R9 irq before edge", {7'b0, alarmIrq}, 8'h00);
    @(negedge clk);
    chk("R9 irq after edge", {7'b0, alarmIrq}, 8'h01);
    rdReg(3'd7, d); chk("R3 month 0x12 match", d, 8'h01);

    done = 1;
    summary();
  end
endmodule